// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block computes and commits the architectural state change a processor core makes when it takes an exception. Each cycle the core presents a vector of exception requests, a small cause code, the address of the current instruction, its current machine state word and the faulting effective address. When at least one request is present, the unit picks the winner and commits new values into its registers on the next clock edge. These registers are the saved return address, the saved state word, the new machine state word and the data fault address and status pair. In the same cycle it raises a one-cycle redirect pulse that carries the handler fetch address.

The new state is the old state with a fixed group of mode bits cleared and the 64-bit mode bit forced on. The saved state is a filtered copy of the old state, with the exception's cause bits ORed in. The handler address is a fixed per-exception offset. It is added to a vector base that is all ones in its upper bits when the new state's vector-prefix bit is set, and zero otherwise. An old state whose recoverable bit is clear marks the entry as a double fault.

Bit positions below use MSB-0 numbering: bit k of a 64-bit word is LSB-0 bit 63-k, and bit k of the 32-bit fault status is LSB-0 bit 31-k. Request index i is `exc_req[i]`: 0 machine check, 1 data storage, 2 instruction storage, 3 external, 4 alignment, 5 program, 6 FP unavailable, 7 decrementer, 8 system call, 9 FP assist.

Top module: `exc_entry_unit`

## Requirements
- R1: On entry, `new_state` equals `cur_state` with state bits 45, 48, 49, 50, 52, 53, 54, 55, 58, 59 and 62 cleared and bit 0 (64-bit mode) set.
- R2: On entry, `save_state` equals `cur_state` ANDed with a mask of bits 0–32, 37–41 and 48–63, ORed with the cause bits of R8.
- R3: `redirect_pc` equals the vector base plus the offset. The base is all ones in bits 0–43 when bit 57 of the new state is set, and zero otherwise. The offsets for indices 0..9 are 0x200, 0x300, 0x400, 0x500, 0x600, 0x700, 0x800, 0x900, 0xC00 and 0xE00.
- R4: On entry, `save_pc` gets `cur_pc`, or `cur_pc + 4` for a system call.
- R5: `double_fault` pulses together with the redirect exactly when bit 62 of the old state was clear.
- R6: A data storage entry loads `fault_addr` with `fault_ea`. It loads `fault_status` with one cause bit chosen by `cause_code`: 0 direct-store error → bit 0, 1 table miss → bit 1, 2 protection → bit 4, 3 external-access violation → bit 5, 4 segment miss → bit 10, 5 external-access disabled → bit 11, 6 and 7 → none. Bit 6 is ORed in when `is_store` is high.
- R7: An alignment entry loads `fault_addr` with `fault_ea` and clears `fault_status`.
- R8: Only instruction storage and program entries add cause bits to `save_state`. For instruction storage, code 0 (table miss) sets bit 33, code 1 (direct-store) sets bit 35, code 2 (protection) sets bit 36 and code 3 (segment miss) sets bit 42. For program, code 0 (FP enabled) sets bit 43, codes 1 (illegal) and 4 (optional unsupported) both set bit 44, code 2 (privileged) sets bit 45 and code 3 (trap) sets bit 46. All other codes add nothing.
- R9: All register updates of one entry become visible one clock after the request cycle. `redirect_valid` is high for exactly that cycle, and with no request the registers hold.
- R10: When several requests are present, the lowest index (smallest offset) is taken.
- R11: After reset every output is zero.
- R12: Entries other than data storage and alignment leave `fault_addr` and `fault_status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 10 | Exception requests, index per the table above |
| cause_code | input | 3 | Cause code for data storage, instruction storage and program |
| is_store | input | 1 | Faulting data access was a store |
| cur_pc | input | 64 | Address of the current instruction |
| cur_state | input | 64 | Current machine state word |
| fault_ea | input | 64 | Faulting effective / operand address |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | 64 | Handler fetch address |
| save_pc | output | 64 | Saved return address register |
| save_state | output | 64 | Saved state register |
| new_state | output | 64 | New machine state register |
| fault_addr | output | 64 | Data fault address register |
| fault_status | output | 32 | Data fault status register |
| double_fault | output | 1 | Entry taken with the recoverable bit clear |

## Verification
Every result is due exactly one clock after the cycle in which the request is presented. This covers the redirect pulse and its address, the four register updates and the double-fault flag. No result appears earlier, and no result depends on a later cycle. The bench drives inputs on the falling edge and updates its behavioural model at the rising edge from the same inputs. On the next falling edge it compares every output with the model. A result that is late or early by one cycle therefore shows up as a mismatch in that cycle. Held values are checked during idle cycles and during entries that must not touch the fault registers.

// File: rtl/exc_pkg.sv
// Shared constants, kinds and helpers for the exception entry unit.
// Assumes a 64-bit state word and 32-bit fault status; positions are MSB-0.
package exc_pkg;

    localparam int XLEN     = 64;
    localparam int STAT_W   = 32;
    localparam int NUM_EXC  = 10;
    localparam int KIND_W   = 4;
    localparam int CODE_W   = 3;
    localparam int BASE_LOW = 20;  // bits below the vector base

    typedef enum logic [KIND_W-1:0] {
        EXC_MCHK    = 4'd0,
        EXC_DSTOR   = 4'd1,
        EXC_ISTOR   = 4'd2,
        EXC_EXTERN  = 4'd3,
        EXC_ALIGN   = 4'd4,
        EXC_PROG    = 4'd5,
        EXC_FPUNAV  = 4'd6,
        EXC_DECR    = 4'd7,
        EXC_SYSCALL = 4'd8,
        EXC_FPASST  = 4'd9
    } exc_kind_e;

    // One-hot word from an MSB-0 position
    function automatic logic [XLEN-1:0] wbit(input int unsigned pos);
        logic [XLEN-1:0] v;
        v = '0;
        v[XLEN-1-pos] = 1'b1;
        return v;
    endfunction

    // One-hot status word from an MSB-0 position
    function automatic logic [STAT_W-1:0] sbit(input int unsigned pos);
        logic [STAT_W-1:0] v;
        v = '0;
        v[STAT_W-1-pos] = 1'b1;
        return v;
    endfunction

    localparam logic [XLEN-1:0] ST_CLEAR =
        wbit(45) | wbit(48) | wbit(49) | wbit(50) | wbit(52) | wbit(53) |
        wbit(54) | wbit(55) | wbit(58) | wbit(59) | wbit(62);
    localparam logic [XLEN-1:0] ST_WIDE   = wbit(0);
    localparam logic [XLEN-1:0] ST_PREFIX = wbit(57);
    localparam int              RECOV_LSB = XLEN - 1 - 62;
    localparam logic [XLEN-1:0] SAVE_KEEP =
        {{33{1'b1}}, 4'b0000, 5'b11111, 6'b000000, {16{1'b1}}};
    localparam logic [XLEN-1:0] VEC_BASE  =
        {{(XLEN-BASE_LOW){1'b1}}, {BASE_LOW{1'b0}}};

    // Saved-state cause bits
    localparam logic [XLEN-1:0] SV_I_MISS  = wbit(33);
    localparam logic [XLEN-1:0] SV_I_DSTR  = wbit(35);
    localparam logic [XLEN-1:0] SV_I_PROT  = wbit(36);
    localparam logic [XLEN-1:0] SV_I_SEG   = wbit(42);
    localparam logic [XLEN-1:0] SV_P_FP    = wbit(43);
    localparam logic [XLEN-1:0] SV_P_ILL   = wbit(44);
    localparam logic [XLEN-1:0] SV_P_PRIV  = wbit(45);
    localparam logic [XLEN-1:0] SV_P_TRAP  = wbit(46);
    localparam logic [XLEN-1:0] SV_CAUSES  =
        SV_I_MISS | SV_I_DSTR | SV_I_PROT | SV_I_SEG |
        SV_P_FP | SV_P_ILL | SV_P_PRIV | SV_P_TRAP;

    // Fault status bits
    localparam logic [STAT_W-1:0] FS_DSTR  = sbit(0);
    localparam logic [STAT_W-1:0] FS_MISS  = sbit(1);
    localparam logic [STAT_W-1:0] FS_PROT  = sbit(4);
    localparam logic [STAT_W-1:0] FS_XVIOL = sbit(5);
    localparam logic [STAT_W-1:0] FS_STORE = sbit(6);
    localparam logic [STAT_W-1:0] FS_SEG   = sbit(10);
    localparam logic [STAT_W-1:0] FS_XDIS  = sbit(11);

    // Handler offset per exception kind
    function automatic logic [XLEN-1:0] vec_offset(input exc_kind_e k);
        logic [XLEN-1:0] o;
        case (k)
            EXC_MCHK:    o = 64'h200;
            EXC_DSTOR:   o = 64'h300;
            EXC_ISTOR:   o = 64'h400;
            EXC_EXTERN:  o = 64'h500;
            EXC_ALIGN:   o = 64'h600;
            EXC_PROG:    o = 64'h700;
            EXC_FPUNAV:  o = 64'h800;
            EXC_DECR:    o = 64'h900;
            EXC_SYSCALL: o = 64'hC00;
            EXC_FPASST:  o = 64'hE00;
            default:     o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
// Fixed-priority picker: the lowest set request index wins.
// Assumes request index order matches ascending handler offset.
module exc_arbiter #(
    parameter int N  = 10,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] grant_idx,
    output logic          any
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // Prefix chain: each request is blocked by any lower-index request
    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            assign grant[i]  = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
        end
    endgenerate

    assign any = seen[N];

    // Encode the one-hot grant into an index
    always_comb begin
        grant_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) grant_idx = IW'(i);
        end
    end

endmodule

// File: rtl/exc_state_calc.sv
// Computes new state, saved state, saved address and handler address
// for the winning exception. Purely combinational.
module exc_state_calc
    import exc_pkg::*;
(
    input  exc_kind_e           kind,
    input  logic [CODE_W-1:0]   code,
    input  logic [XLEN-1:0]     pc,
    input  logic [XLEN-1:0]     state,
    output logic [XLEN-1:0]     next_state,
    output logic [XLEN-1:0]     saved_state,
    output logic [XLEN-1:0]     saved_pc,
    output logic [XLEN-1:0]     target_pc
);

    logic [XLEN-1:0] cause;

    // Decode the cause bits that go into the saved state
    always_comb begin
        cause = '0;
        if (kind == EXC_ISTOR) begin
            case (code)
                3'd0:    cause = SV_I_MISS;
                3'd1:    cause = SV_I_DSTR;
                3'd2:    cause = SV_I_PROT;
                3'd3:    cause = SV_I_SEG;
                default: cause = '0;
            endcase
        end else if (kind == EXC_PROG) begin
            case (code)
                3'd0:       cause = SV_P_FP;
                3'd1, 3'd4: cause = SV_P_ILL;
                3'd2:       cause = SV_P_PRIV;
                3'd3:       cause = SV_P_TRAP;
                default:    cause = '0;
            endcase
        end
    end

    // Build the state words, return address and handler address
    always_comb begin
        next_state  = (state & ~ST_CLEAR) | ST_WIDE;
        saved_state = (state & SAVE_KEEP) | cause;
        saved_pc    = (kind == EXC_SYSCALL) ? pc + XLEN'(4) : pc;
        target_pc   = (((next_state & ST_PREFIX) != '0) ? VEC_BASE : '0)
                      + vec_offset(kind);
    end

endmodule

// File: rtl/exc_fault_calc.sv
// Decides whether the data fault registers load, and with what.
// Only data storage and alignment entries touch them.
module exc_fault_calc
    import exc_pkg::*;
(
    input  exc_kind_e           kind,
    input  logic [CODE_W-1:0]   code,
    input  logic                is_store,
    input  logic [XLEN-1:0]     ea,
    output logic                load,
    output logic [XLEN-1:0]     addr_val,
    output logic [STAT_W-1:0]   stat_val
);

    // Select load enable and status for the winning kind
    always_comb begin
        load     = 1'b0;
        addr_val = ea;
        stat_val = '0;
        if (kind == EXC_DSTOR) begin
            load = 1'b1;
            case (code)
                3'd0:    stat_val = FS_DSTR;
                3'd1:    stat_val = FS_MISS;
                3'd2:    stat_val = FS_PROT;
                3'd3:    stat_val = FS_XVIOL;
                3'd4:    stat_val = FS_SEG;
                3'd5:    stat_val = FS_XDIS;
                default: stat_val = '0;
            endcase
            if (is_store) stat_val = stat_val | FS_STORE;
        end else if (kind == EXC_ALIGN) begin
            load     = 1'b1;
            stat_val = '0;
        end
    end

endmodule

// File: rtl/exc_entry_unit.sv
// Exception entry unit top: picks the winning request, computes the
// entry values and commits them all on one clock edge with a redirect
// pulse. Assumes the core gates maskable requests before they arrive.
module exc_entry_unit
    import exc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EXC-1:0]   exc_req,
    input  logic [CODE_W-1:0]    cause_code,
    input  logic                 is_store,
    input  logic [XLEN-1:0]      cur_pc,
    input  logic [XLEN-1:0]      cur_state,
    input  logic [XLEN-1:0]      fault_ea,
    output logic                 redirect_valid,
    output logic [XLEN-1:0]      redirect_pc,
    output logic [XLEN-1:0]      save_pc,
    output logic [XLEN-1:0]      save_state,
    output logic [XLEN-1:0]      new_state,
    output logic [XLEN-1:0]      fault_addr,
    output logic [STAT_W-1:0]    fault_status,
    output logic                 double_fault
);

    logic [NUM_EXC-1:0] grant;
    logic [KIND_W-1:0]  win_idx;
    logic               take;
    exc_kind_e          win_kind;
    logic [XLEN-1:0]    nx_state, nx_saved, nx_pc, nx_target;
    logic               f_load;
    logic [XLEN-1:0]    f_addr;
    logic [STAT_W-1:0]  f_stat;

    exc_arbiter #(.N(NUM_EXC), .IW(KIND_W)) u_arb (
        .req       (exc_req),
        .grant     (grant),
        .grant_idx (win_idx),
        .any       (take)
    );

    assign win_kind = exc_kind_e'(win_idx);

    exc_state_calc u_state (
        .kind        (win_kind),
        .code        (cause_code),
        .pc          (cur_pc),
        .state       (cur_state),
        .next_state  (nx_state),
        .saved_state (nx_saved),
        .saved_pc    (nx_pc),
        .target_pc   (nx_target)
    );

    exc_fault_calc u_fault (
        .kind     (win_kind),
        .code     (cause_code),
        .is_store (is_store),
        .ea       (fault_ea),
        .load     (f_load),
        .addr_val (f_addr),
        .stat_val (f_stat)
    );

    // Redirect pulse and double-fault flag, one cycle per entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            double_fault   <= 1'b0;
        end else begin
            redirect_valid <= take;
            double_fault   <= take & ~cur_state[RECOV_LSB];
            if (take) redirect_pc <= nx_target;
        end
    end

    // Architectural registers written on entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_pc    <= '0;
            save_state <= '0;
            new_state  <= '0;
        end else if (take) begin
            save_pc    <= nx_pc;
            save_state <= nx_saved;
            new_state  <= nx_state;
        end
    end

    // Data fault address and status, written only by their two kinds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_addr   <= '0;
            fault_status <= '0;
        end else if (take && f_load) begin
            fault_addr   <= f_addr;
            fault_status <= f_stat;
        end
    end

    // grant is consumed via its index; keep it observable to the checker
    logic unused_grant;
    assign unused_grant = ^grant;

endmodule

// Property checker for the exception entry unit.
module exc_entry_unit_chk
    import exc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_EXC-1:0]   exc_req,
    input logic [XLEN-1:0]      cur_state,
    input logic                 redirect_valid,
    input logic [XLEN-1:0]      redirect_pc,
    input logic [XLEN-1:0]      save_pc,
    input logic [XLEN-1:0]      save_state,
    input logic [XLEN-1:0]      new_state,
    input logic [XLEN-1:0]      fault_addr,
    input logic [STAT_W-1:0]    fault_status,
    input logic                 double_fault
);

    a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|exc_req) |=> redirect_valid);

    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(|exc_req) |=> !redirect_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(|exc_req) |=> ($stable(save_pc) && $stable(save_state) && $stable(new_state)));

    a_r1_mode: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (new_state[XLEN-1] && ((new_state & ST_CLEAR) == '0)));

    a_r2_filter: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> ((save_state & ~(SAVE_KEEP | SV_CAUSES)) == '0));

    a_r3_offset: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (redirect_pc[7:0] == 8'h00));

    a_r5_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|exc_req) |=> (double_fault == !$past(cur_state[RECOV_LSB])));

    a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(|exc_req) |=> !double_fault);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req == 10'b00_0001_0000) |=> (fault_status == '0));

    a_r12_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_req[1] && !exc_req[4]) |=> ($stable(fault_addr) && $stable(fault_status)));

endmodule

bind exc_entry_unit exc_entry_unit_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .exc_req        (exc_req),
    .cur_state      (cur_state),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .save_pc        (save_pc),
    .save_state     (save_state),
    .new_state      (new_state),
    .fault_addr     (fault_addr),
    .fault_status   (fault_status),
    .double_fault   (double_fault)
);

// File: tb/exc_entry_unit_test.sv
// Self-checking bench: behavioural reference model updated at each
// rising edge, all outputs compared at every falling edge.
module exc_entry_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  exc_req = '0;
    logic [2:0]  cause_code = '0;
    logic        is_store = 1'b0;
    logic [63:0] cur_pc = '0, cur_state = '0, fault_ea = '0;
    logic        redirect_valid, double_fault;
    logic [63:0] redirect_pc, save_pc, save_state, new_state, fault_addr;
    logic [31:0] fault_status;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // Model state
    logic        m_valid = 0, m_dbl = 0;
    logic [63:0] m_rpc = 0, m_spc = 0, m_sst = 0, m_nst = 0, m_fa = 0;
    logic [31:0] m_fs = 0;

    exc_entry_unit uut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .cause_code(cause_code),
        .is_store(is_store), .cur_pc(cur_pc), .cur_state(cur_state),
        .fault_ea(fault_ea), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .save_pc(save_pc), .save_state(save_state),
        .new_state(new_state), .fault_addr(fault_addr),
        .fault_status(fault_status), .double_fault(double_fault)
    );

    always #4 clk = ~clk;  // 125 MHz

    function automatic logic [63:0] w0(int k);
        return 64'd1 << (63 - k);
    endfunction

    function automatic logic [31:0] s0(int k);
        return 32'd1 << (31 - k);
    endfunction

    // Reference model: one entry per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 0; m_dbl = 0; m_rpc = 0; m_spc = 0; m_sst = 0;
            m_nst = 0; m_fa = 0; m_fs = 0;
        end else begin
            int win;
            logic [63:0] clr, keep, base, cause;
            win = -1;
            for (int i = 9; i >= 0; i--) if (exc_req[i]) win = i; // R10
            m_valid = (win >= 0);
            m_dbl = 0;
            if (win >= 0) begin
                clr = w0(45)|w0(48)|w0(49)|w0(50)|w0(52)|w0(53)|w0(54)|
                      w0(55)|w0(58)|w0(59)|w0(62);
                m_nst = (cur_state & ~clr) | w0(0);
                keep = 0;
                for (int k = 0; k < 64; k++)
                    if (k <= 32 || (k >= 37 && k <= 41) || k >= 48) keep |= w0(k);
                cause = 0;
                if (win == 2) case (cause_code)
                    0: cause = w0(33); 1: cause = w0(35);
                    2: cause = w0(36); 3: cause = w0(42); default: ;
                endcase
                if (win == 5) case (cause_code)
                    0: cause = w0(43); 1, 4: cause = w0(44);
                    2: cause = w0(45); 3: cause = w0(46); default: ;
                endcase
                m_sst = (cur_state & keep) | cause;
                m_spc = (win == 8) ? cur_pc + 4 : cur_pc;
                base = 0;
                if ((m_nst & w0(57)) != 0)
                    for (int k = 0; k <= 43; k++) base |= w0(k);
                case (win)
                    8: m_rpc = base + 64'hC00;
                    9: m_rpc = base + 64'hE00;
                    default: m_rpc = base + 64'h200 + 64'h100 * win;
                endcase
                m_dbl = ((cur_state & w0(62)) == 0);
                if (win == 1) begin
                    m_fa = fault_ea;
                    case (cause_code)
                        0: m_fs = s0(0); 1: m_fs = s0(1); 2: m_fs = s0(4);
                        3: m_fs = s0(5); 4: m_fs = s0(10); 5: m_fs = s0(11);
                        default: m_fs = 0;
                    endcase
                    if (is_store) m_fs |= s0(6);
                end else if (win == 4) begin
                    m_fa = fault_ea;
                    m_fs = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cycles, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R9 redirect_valid", {63'd0, redirect_valid}, {63'd0, m_valid});
        chk("R3 redirect_pc", redirect_pc, m_rpc);
        chk("R4 save_pc", save_pc, m_spc);
        chk("R2 R8 save_state", save_state, m_sst);
        chk("R1 new_state", new_state, m_nst);
        chk("R6 R7 R12 fault_addr", fault_addr, m_fa);
        chk("R6 R7 R12 fault_status", {32'd0, fault_status}, {32'd0, m_fs});
        chk("R5 double_fault", {63'd0, double_fault}, {63'd0, m_dbl});
    endtask

    // Apply one cycle of stimulus after checking the previous one
    task automatic step(input logic [9:0] r, input logic [2:0] c, input logic st,
                        input logic [63:0] pc, input logic [63:0] s, input logic [63:0] ea);
        @(negedge clk);
        compare_all();
        exc_req = r; cause_code = c; is_store = st;
        cur_pc = pc; cur_state = s; fault_ea = ea;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog expired: actual=%0d expected<=100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [63:0] RI_ON = 64'h2;     // recoverable bit set
    localparam logic [63:0] PFX   = 64'h40;    // vector-prefix bit

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values
        chk("R11 reset redirect_pc", redirect_pc, 64'd0);
        chk("R11 reset save_state", save_state, 64'd0);
        chk("R11 reset fault_status", {32'd0, fault_status}, 64'd0);
        chk("R11 reset valid", {63'd0, redirect_valid}, 64'd0);
        rst_n = 1'b1;
        // R1 R3 R4: each kind alone, prefix off then on
        for (int i = 0; i < 10; i++)
            step(10'd1 << i, 3'd0, 1'b0, 64'h1000 + 64'(i * 16), 64'hFFFF_FFFF_FFFF_FFBF, 64'hA0);
        for (int i = 0; i < 10; i++)
            step(10'd1 << i, 3'd1, 1'b1, 64'h2000 + 64'(i * 8), PFX | RI_ON | 64'h8000, 64'hB0);
        step(0, 0, 0, 0, 0, 0);
        // R6: data storage codes, load and store
        for (int c = 0; c < 8; c++) begin
            step(10'b10, 3'(c), 1'b0, 64'h300, RI_ON, 64'hDEAD_0000 + 64'(c));
            step(10'b10, 3'(c), 1'b1, 64'h304, RI_ON, 64'hBEEF_0000 + 64'(c));
        end
        // R7: alignment after a data fault clears status
        step(10'b1_0000, 3'd7, 1'b1, 64'h600, RI_ON, 64'h1234_5677);
        // R8: instruction storage and program codes
        for (int c = 0; c < 8; c++) begin
            step(10'b100, 3'(c), 1'b0, 64'h400, 64'hFFFF_FFFF_FFFF_FFFF, 0);
            step(10'b10_0000, 3'(c), 1'b0, 64'h700, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        end
        // R10: simultaneous requests, lowest index wins
        step(10'b11_1111_1110, 3'd2, 1'b1, 64'h900, RI_ON, 64'hCAFE);
        step(10'b11_0010_0000, 3'd3, 1'b0, 64'h904, RI_ON, 64'hCAFF);
        step(10'b11_0000_0000, 3'd0, 1'b0, 64'h908, RI_ON, 64'hCB00);
        // R12: other kinds leave fault registers alone
        step(10'b00_1000_1000, 3'd0, 1'b1, 64'h90C, RI_ON, 64'hFFFF);
        // R5: recoverable bit clear on entry
        step(10'b1, 3'd0, 1'b0, 64'hA00, 64'h0, 0);
        step(0, 0, 0, 0, 0, 0);
        // R9: idle cycles hold
        repeat (3) step(0, 0, 0, 64'h5555, 64'hFFFF, 64'h7777);
        // Mixed patterns
        for (int n = 0; n < 400; n++) begin
            logic [9:0] r;
            r = ($urandom % 3 == 0) ? 10'd0 :
                ($urandom % 2 == 0) ? (10'd1 << ($urandom % 10)) : 10'($urandom);
            step(r, 3'($urandom), 1'($urandom), {$urandom, $urandom},
                 {$urandom, $urandom}, {$urandom, $urandom});
        end
        step(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare_all();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule